// File: doc/BRIEF.md
# Four-Function Ripple ALU

A combinational arithmetic-logic unit of parameterised width (4 bits by default). Every result, arithmetic or logic, comes out of one ripple chain of full adders. At each bit position three small extenders sit in front of the adder. The logic extender forms the adder's first input. The arithmetic extender forms its second input. A single carry extender drives the carry into bit 0.

For the two logic operations, the second adder input and the carry-in are held at zero, so the adder simply passes the logic extender's output through. No separate output multiplexer is needed.

The block also reports a carry-out, unsigned and signed overflow flags, and a zero flag. It is used wherever a datapath needs subtract, decrement, OR and NAND in a single stage with no clock.

Top module: `ripple_alu`

## Requirements
- R1: With op_i = 2'b00, result_o equals a_i minus b_i, modulo 2^W.
- R2: With op_i = 2'b01, result_o equals a_i minus 1, modulo 2^W (an all-zero a_i gives all ones).
- R3: With op_i = 2'b10, result_o equals the bitwise OR of a_i and b_i.
- R4: With op_i = 2'b11, result_o equals the bitwise NAND of a_i and b_i.
- R5: For op_i = 2'b00 and 2'b01, carry_o is the carry out of the top adder. It is 1 exactly when no borrow occurs: a_i >= b_i for subtract, and a_i != 0 for decrement.
- R6: For op_i = 2'b10 and 2'b11, carry_o, uovf_o and sovf_o are all 0.
- R7: For op_i = 2'b00 and 2'b01, uovf_o is 1 exactly when the unsigned result wraps below zero. This is a_i < b_i for subtract, and a_i == 0 for decrement.
- R8: For op_i = 2'b00 and 2'b01, sovf_o is 1 exactly when the two's-complement result falls outside [-2^(W-1), 2^(W-1)-1]. This is the same as the carry into the top bit differing from the carry out of it.
- R9: zero_o is 1 exactly when every bit of result_o is 0, for all four operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (not used by decrement) |
| op_i | input | 2 | Operation: 00 subtract, 01 decrement, 10 OR, 11 NAND |
| result_o | output | W | Result |
| carry_o | output | 1 | Adder carry-out (arithmetic operations only) |
| uovf_o | output | 1 | Unsigned wrap (borrow) |
| sovf_o | output | 1 | Two's-complement overflow |
| zero_o | output | 1 | Result is all zeros |

## Verification
The block is purely combinational, so every output is due in the same cycle as its operands, zero clock edges later. The driver changes a_i, b_i and op_i just after a rising edge and pushes the expected item at the same moment. The monitor pops that item and compares it on the following falling edge, half a period later, when the ripple chain has long settled. Stimulus covers all four operations over corner operands (zero, all ones, the signed extremes, equal operands), followed by random operands.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;
  typedef enum logic [1:0] {
    OP_SUB  = 2'b00,
    OP_DEC  = 2'b01,
    OP_OR   = 2'b10,
    OP_NAND = 2'b11
  } alu_op_e;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_DEC);
  endfunction
endpackage

// File: rtl/alu_logic_ext.sv
module alu_logic_ext
  import ripple_alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    a_i,
  input  logic    b_i,
  output logic    x_o
);
  always_comb begin
    unique case (op_i)
      OP_OR:   x_o = a_i | b_i;
      OP_NAND: x_o = ~(a_i & b_i);
      default: x_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_arith_ext.sv
module alu_arith_ext
  import ripple_alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    b_i,
  output logic    y_o
);
  always_comb begin
    unique case (op_i)
      OP_SUB:  y_o = ~b_i;
      OP_DEC:  y_o = 1'b1;
      default: y_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_carry_ext.sv
module alu_carry_ext
  import ripple_alu_pkg::*;
(
  input  alu_op_e op_i,
  output logic    cin_o
);
  assign cin_o = (op_i == OP_SUB);
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         uovf_o,
  output logic         sovf_o,
  output logic         zero_o
);
  localparam int MSB = W - 1;

  alu_op_e       op;
  logic [W:0]    c;
  logic [W-1:0]  x;
  logic [W-1:0]  y;
  logic          arith;

  assign op    = alu_op_e'(op_i);
  assign arith = op_is_arith(op);

  alu_carry_ext u_cext (.op_i(op), .cin_o(c[0]));

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_logic_ext u_lext (.op_i(op), .a_i(a_i[i]), .b_i(b_i[i]), .x_o(x[i]));
    alu_arith_ext u_aext (.op_i(op), .b_i(b_i[i]), .y_o(y[i]));
    alu_full_adder u_fa (
      .x_i(x[i]), .y_i(y[i]), .c_i(c[i]),
      .s_o(result_o[i]), .c_o(c[i+1])
    );
  end

  assign carry_o = arith & c[W];
  assign uovf_o  = arith & ~c[W];
  assign sovf_o  = arith & (c[MSB] ^ c[W]);
  assign zero_o  = ~|result_o;

  always_comb begin
    if (op == OP_SUB)
      a_r1_sub: assert (result_o == W'(a_i - b_i));
    if (op == OP_DEC)
      a_r2_dec: assert (result_o == W'(a_i - W'(1)));
    if (op == OP_OR)
      a_r3_or: assert (result_o == (a_i | b_i));
    if (op == OP_NAND)
      a_r4_nand: assert (result_o == ~(a_i & b_i));
    if (!arith)
      a_r6_logic_no_carry: assert (c[W] == 1'b0 && y == '0);
    if (op == OP_SUB)
      a_r5_sub_noborrow: assert (carry_o == (a_i >= b_i));
  end
endmodule

// File: tb/ripple_alu_bench.sv
module ripple_alu_bench;
  localparam int W = 4;
  localparam int MAXU = (1 << W);

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         uo;
    logic         so;
    logic         z;
    logic [1:0]   op;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [1:0]   op;
  logic         cy, uo, so, z;

  ripple_alu #(.W(W)) u_ripple_alu (
    .a_i(a), .b_i(b), .op_i(op), .result_o(res),
    .carry_o(cy), .uovf_o(uo), .sovf_o(so), .zero_o(z)
  );

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic int sval(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - MAXU : int'(v);
  endfunction

  task automatic drive(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] yv);
    exp_t e;
    int d, s;
    @(posedge clk);
    #1;
    a = x; b = yv; op = o;
    e.op = o;
    e.cy = 0; e.uo = 0; e.so = 0;
    case (o)
      2'b00: begin
        d = int'(x) - int'(yv);
        s = sval(x) - sval(yv);
        e.res = W'(d);
        e.cy = (d >= 0); e.uo = (d < 0);
        e.so = (s < -(MAXU/2)) || (s > MAXU/2 - 1);
      end
      2'b01: begin
        d = int'(x) - 1;
        s = sval(x) - 1;
        e.res = W'(d);
        e.cy = (d >= 0); e.uo = (d < 0);
        e.so = (s < -(MAXU/2));
      end
      2'b10: e.res = x | yv;
      default: e.res = ~(x & yv);
    endcase
    e.z = (e.res == '0);
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", req, op, a, b, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      case (e.op)
        2'b00: chk(res == e.res, "R1", res, e.res);
        2'b01: chk(res == e.res, "R2", res, e.res);
        2'b10: chk(res == e.res, "R3", res, e.res);
        default: chk(res == e.res, "R4", res, e.res);
      endcase
      if (e.op[1]) begin
        chk(cy == 0 && uo == 0 && so == 0, "R6", {cy, uo, so}, 0);
      end else begin
        chk(cy == e.cy, "R5", cy, e.cy);
        chk(uo == e.uo, "R7", uo, e.uo);
        chk(so == e.so, "R8", so, e.so);
      end
      chk(z == e.z, "R9", z, e.z);
    end
  end

  initial begin
    for (int n = 0; n < 5000; n++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; op = 2'b10;
    #2;
    chk(res == '0 && z == 1'b1, "R9", res, 0);
    for (int o = 0; o < 4; o++) begin
      drive(2'(o), 4'h0, 4'h0);
      drive(2'(o), 4'hF, 4'hF);
      drive(2'(o), 4'h7, 4'h8);
      drive(2'(o), 4'h8, 4'h1);
      drive(2'(o), 4'h8, 4'h7);
      drive(2'(o), 4'h5, 4'h5);
      drive(2'(o), 4'h3, 4'hA);
      drive(2'(o), 4'h1, 4'h0);
    end
    for (int a0 = 0; a0 < MAXU; a0++)
      for (int b0 = 0; b0 < MAXU; b0++)
        for (int o = 0; o < 4; o++)
          drive(2'(o), W'(a0), W'(b0));
    for (int n = 0; n < 300; n++)
      drive(2'($urandom_range(0, 3)), W'($urandom), W'($urandom));
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule